// File: doc/BRIEF.md
# Latched Status and Interrupt Controller

This block collects alarm conditions and one-shot event pulses from line-interface logic into a bank of byte-wide latched status registers. Each register has a mask register of its own. A summary register gives one bit per status register, so the host can find the register that needs service with a single read. One active-low interrupt output is asserted while any latched bit has its mask bit set.

The host uses a synchronous register port with address, write data, write strobe, read strobe and read data. To read a status register, the host first writes a selection byte to its address. Bit positions written as one copy the current latched value into a readable shadow. Bit positions written as zero keep the shadow's earlier value. The read that follows returns the shadow. It clears only the latched bits that were selected and that the shadow shows as one, so an occurrence that arrives after the selection write is not lost.

Most bits latch on the level of their input. An input that is active only briefly therefore behaves as an event, and an input that stays active behaves as a persistent condition. Bits marked as two-edge latch on every change of their input, so a condition raises a request when it begins and again when it ends. A paired bit in the upper half of a register latches when the condition bit four positions below it goes inactive.

Top module: `latched_stat_irq`

## Requirements
- R1: After reset every status latch, selection, shadow and mask is zero. Every address 0 to 8 reads 0x00, and irq_no is 1.
- R2: A non-two-edge input bit that is high at a clock edge sets its latch. The latch stays set after the input falls, until a clearing read.
- R3: A write to status address r (r in 0..3) refreshes shadow bits where the written byte has ones, from the current latches, and keeps the other shadow bits. A read of address r returns the shadow.
- R4: A read of status address r clears only the latched bits that the last selection write to r selected and that the shadow returned as one. No latch is cleared without a read.
- R5: A level-latched bit whose input is still high when it is read returns one and stays set.
- R6: If a bit's input sets it in the same cycle as a read that clears it, the bit stays set. The read returns the shadow value held before that cycle.
- R7: irq_no is 0 exactly when some latched bit has its mask bit set. Masks are written and read at addresses 4 to 7 (mask for status r at 4+r).
- R8: Address 8 reads the summary. Bit r is one when status r has a latched bit with its mask set, and bits 7..4 read zero.
- R9: Bit 1 of every register is two-edge. It latches on each rising and each falling edge of its input, and a read clears it even while the input is still high.
- R10: Bit 4 of every register latches one cycle after bit 0's input goes from high to low.
- R11: Writes to address 8 have no effect, and addresses 9 to 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data (selection byte or mask) |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; a read of a status address clears bits |
| rdata_o | output | 8 | Read data for addr_i |
| alarm_i | input | 32 | Raw inputs, register r bit b at index 8r+b |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The clearing read and a new setting of the same latch can fall in the same cycle. The bench provokes this by raising an input exactly during the read strobe of a bit that is selected and shown as one. It judges the result by the value returned in that cycle and by two later select-and-read pairs: the first must still report the bit, and the second must report it cleared. A separate sequence checks that a bit which latches after the selection write survives the read, because its shadow bit is still zero.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  typedef enum logic [1:0] {
    RGN_STAT,
    RGN_MASK,
    RGN_SUM,
    RGN_NONE
  } region_e;
endpackage

// File: rtl/stat_addr_decode.sv
module stat_addr_decode
  import stat_irq_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int AW       = 4,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [AW-1:0]    addr_i,
  output region_e          region_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [AW-1:0] mask_off;

  assign mask_off = addr_i - AW'(NUM_REGS);

  always_comb begin
    region_o = RGN_NONE;
    idx_o    = '0;
    if (addr_i < AW'(NUM_REGS)) begin
      region_o = RGN_STAT;
      idx_o    = addr_i[IDX_W-1:0];
    end else if (addr_i < AW'(2 * NUM_REGS)) begin
      region_o = RGN_MASK;
      idx_o    = mask_off[IDX_W-1:0];
    end else if (addr_i == AW'(2 * NUM_REGS)) begin
      region_o = RGN_SUM;
    end
  end
endmodule

// File: rtl/stat_edge_set.sv
module stat_edge_set #(
  parameter int             DW        = 8,
  parameter logic [DW-1:0]  DBL_MASK  = 8'h02,
  parameter logic [DW/2-1:0] PAIR_MASK = 4'h1,
  localparam int            HALF      = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] raw_i,
  output logic [DW-1:0] set_o
);
  logic [DW-1:0] prev_q;
  logic [DW-1:0] fell;
  logic [DW-1:0] pair_w;

  assign pair_w = {{(DW - HALF){1'b0}}, PAIR_MASK};
  assign fell   = prev_q & ~raw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= raw_i;
  end

  // level bits, two-edge bits, and clear-event partner bits
  assign set_o = (raw_i & ~DBL_MASK)
               | ((raw_i ^ prev_q) & DBL_MASK)
               | ((fell & pair_w) << HALF);
endmodule

// File: rtl/stat_reg_slice.sv
module stat_reg_slice #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          sel_we_i,
  input  logic          rd_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] snap_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] sel_o
);
  logic [DW-1:0] stat_q, snap_q, mask_q, sel_q;
  logic [DW-1:0] clr;

  // clear only what was selected and actually shown as one
  assign clr = rd_i ? (sel_q & snap_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      snap_q <= '0;
      mask_q <= '0;
      sel_q  <= '0;
    end else begin
      stat_q <= set_i | (stat_q & ~clr);
      if (sel_we_i) begin
        sel_q  <= wdata_i;
        snap_q <= (wdata_i & stat_q) | (~wdata_i & snap_q);
      end else if (rd_i) begin
        sel_q <= '0;
      end
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign snap_o = snap_q;
  assign mask_o = mask_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/stat_irq_summary.sv
module stat_irq_summary #(
  parameter int NUM_REGS = 4,
  parameter int DW       = 8
) (
  input  logic [NUM_REGS*DW-1:0] stat_i,
  input  logic [NUM_REGS*DW-1:0] mask_i,
  output logic [NUM_REGS-1:0]    sum_o,
  output logic                   irq_no
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sum
    assign sum_o[r] = |(stat_i[r*DW +: DW] & mask_i[r*DW +: DW]);
  end
  assign irq_no = ~(|sum_o);
endmodule

// File: rtl/latched_stat_irq.sv
module latched_stat_irq
  import stat_irq_pkg::*;
#(
  parameter int              NUM_REGS  = 4,
  parameter int              DW        = 8,
  parameter int              AW        = 4,
  parameter logic [DW-1:0]   DBL_MASK  = 8'h02,
  parameter logic [DW/2-1:0] PAIR_MASK = 4'h1,
  localparam int             IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int             TW        = NUM_REGS * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  input  logic [TW-1:0] alarm_i,
  output logic          irq_no
);
  region_e          rgn;
  logic [IDX_W-1:0] idx;
  logic [TW-1:0]    stat_flat, mask_flat, sel_flat;
  logic [DW-1:0]    snap_arr [NUM_REGS];
  logic [DW-1:0]    mask_arr [NUM_REGS];
  logic [NUM_REGS-1:0] sum;

  stat_addr_decode #(.NUM_REGS(NUM_REGS), .AW(AW)) u_dec (
    .addr_i  (addr_i),
    .region_o(rgn),
    .idx_o   (idx)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [DW-1:0] set_v, stat_v, snap_v, mask_v, sel_v;
    logic          hit_stat, hit_mask;

    assign hit_stat = (rgn == RGN_STAT) && (idx == IDX_W'(r));
    assign hit_mask = (rgn == RGN_MASK) && (idx == IDX_W'(r));

    stat_edge_set #(.DW(DW), .DBL_MASK(DBL_MASK), .PAIR_MASK(PAIR_MASK)) u_set (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (alarm_i[r*DW +: DW]),
      .set_o (set_v)
    );

    stat_reg_slice #(.DW(DW)) u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_v),
      .sel_we_i (we_i && hit_stat),
      .rd_i     (re_i && hit_stat),
      .mask_we_i(we_i && hit_mask),
      .wdata_i  (wdata_i),
      .stat_o   (stat_v),
      .snap_o   (snap_v),
      .mask_o   (mask_v),
      .sel_o    (sel_v)
    );

    assign stat_flat[r*DW +: DW] = stat_v;
    assign mask_flat[r*DW +: DW] = mask_v;
    assign sel_flat[r*DW +: DW]  = sel_v;
    assign snap_arr[r]           = snap_v;
    assign mask_arr[r]           = mask_v;
  end

  stat_irq_summary #(.NUM_REGS(NUM_REGS), .DW(DW)) u_sum (
    .stat_i(stat_flat),
    .mask_i(mask_flat),
    .sum_o (sum),
    .irq_no(irq_no)
  );

  always_comb begin
    unique case (rgn)
      RGN_STAT: rdata_o = snap_arr[idx];
      RGN_MASK: rdata_o = mask_arr[idx];
      RGN_SUM:  rdata_o = DW'(sum);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/stat_irq_chk.sv
module stat_irq_chk #(
  parameter int            NUM_REGS = 4,
  parameter int            DW       = 8,
  parameter int            AW       = 4,
  parameter logic [DW-1:0] DBL_MASK = 8'h02,
  localparam int           TW       = NUM_REGS * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic          re_i,
  input logic [AW-1:0] addr_i,
  input logic [TW-1:0] alarm_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_no,
  input logic [TW-1:0] stat_flat,
  input logic [TW-1:0] mask_flat,
  input logic [TW-1:0] sel_flat
);
  localparam logic [TW-1:0] PLAIN = ~{NUM_REGS{DBL_MASK}};

  p_quiet_no_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_flat == '0) |-> irq_no);

  p_pending_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_flat & mask_flat) != '0) |-> !irq_no);

  p_level_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((stat_flat & $past(alarm_i & PLAIN)) == $past(alarm_i & PLAIN)));

  p_no_drop_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(re_i)) |-> (($past(stat_flat) & ~stat_flat) == '0));

  p_drop_only_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (($past(stat_flat) & ~stat_flat & ~$past(sel_flat)) == '0));

  p_mask_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(we_i)) |-> $stable(mask_flat));

  p_sum_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == AW'(2 * NUM_REGS)) |-> (rdata_o[DW-1:NUM_REGS] == '0));
endmodule

bind latched_stat_irq stat_irq_chk #(
  .NUM_REGS(NUM_REGS),
  .DW      (DW),
  .AW      (AW),
  .DBL_MASK(DBL_MASK)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .re_i     (re_i),
  .addr_i   (addr_i),
  .alarm_i  (alarm_i),
  .rdata_o  (rdata_o),
  .irq_no   (irq_no),
  .stat_flat(stat_flat),
  .mask_flat(mask_flat),
  .sel_flat (sel_flat)
);

// File: tb/sim_latched_stat_irq.sv
module sim_latched_stat_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [7:0]  rdata;
  logic [31:0] alarm = '0;
  logic        irq_n;
  int          n_cmp = 0;
  int          n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  latched_stat_irq u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .wdata_i(wdata),
    .we_i   (we),
    .re_i   (re),
    .rdata_o(rdata),
    .alarm_i(alarm),
    .irq_no (irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic sel_rd(input logic [3:0] a, input logic [7:0] s, input logic [7:0] exp, input string req);
    wr(a, s);
    rd_chk(a, exp, req);
  endtask

  task automatic pulse(input int r, input int b);
    @(negedge clk); alarm[r*8+b] = 1'b1;
    @(negedge clk); alarm[r*8+b] = 1'b0;
    @(negedge clk);
  endtask

  task automatic irq_chk(input logic exp, input string req);
    chk(req, {7'b0, irq_n}, {7'b0, exp});
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    irq_chk(1'b1, "R1");
    for (int a = 0; a <= 8; a++) rd_chk(4'(a), 8'h00, "R1");

    // sweep every register and bit
    for (int r = 0; r < 4; r++) begin
      for (int b = 0; b < 8; b++) begin
        pulse(r, b);
        rd_chk(4'd8, 8'h00, "R8");
        irq_chk(1'b1, "R7");
        wr(4'(4 + r), 8'(1 << b));
        irq_chk(1'b0, "R7");
        rd_chk(4'd8, 8'(1 << r), "R8");
        sel_rd(4'(r), 8'(1 << b), 8'(1 << b), "R2");
        irq_chk(1'b1, "R4");
        sel_rd(4'(r), 8'(1 << b), 8'h00, "R4");
        wr(4'(4 + r), 8'h00);
        sel_rd(4'(r), 8'hFF, (b == 0) ? 8'h10 : 8'h00, "R10");
        sel_rd(4'(r), 8'hFF, 8'h00, "R4");
      end
    end

    // R3 selective refresh keeps unselected shadow bits
    pulse(1, 2);
    pulse(1, 6);
    sel_rd(4'd1, 8'h04, 8'h04, "R3");
    sel_rd(4'd1, 8'h00, 8'h04, "R3");
    sel_rd(4'd1, 8'h40, 8'h44, "R3");
    sel_rd(4'd1, 8'hFF, 8'h00, "R4");

    // R4 latch after the selection write survives the read
    wr(4'd0, 8'h08);
    pulse(0, 3);
    rd_chk(4'd0, 8'h00, "R4");
    sel_rd(4'd0, 8'h08, 8'h08, "R4");
    sel_rd(4'd0, 8'h08, 8'h00, "R4");

    // R5 persistent condition survives its read
    @(negedge clk); alarm[26] = 1'b1;
    sel_rd(4'd3, 8'h04, 8'h04, "R5");
    sel_rd(4'd3, 8'h04, 8'h04, "R5");
    @(negedge clk); alarm[26] = 1'b0;
    sel_rd(4'd3, 8'h04, 8'h04, "R5");
    sel_rd(4'd3, 8'h04, 8'h00, "R5");

    // R9 two-edge bit: cleared while high, relatched at the end
    @(negedge clk); alarm[25] = 1'b1;
    sel_rd(4'd3, 8'h02, 8'h02, "R9");
    sel_rd(4'd3, 8'h02, 8'h00, "R9");
    @(negedge clk); alarm[25] = 1'b0;
    @(negedge clk);
    wr(4'd7, 8'h02);
    irq_chk(1'b0, "R9");
    sel_rd(4'd3, 8'h02, 8'h02, "R9");
    irq_chk(1'b1, "R9");
    wr(4'd7, 8'h00);

    // R6 set and clearing read in the same cycle
    pulse(2, 3);
    wr(4'd2, 8'h08);
    @(negedge clk); addr = 4'd2; re = 1'b1; alarm[19] = 1'b1;
    #1 d = rdata;
    chk("R6", d, 8'h08);
    @(negedge clk); re = 1'b0; alarm[19] = 1'b0;
    sel_rd(4'd2, 8'h08, 8'h08, "R6");
    sel_rd(4'd2, 8'h08, 8'h00, "R6");

    // R8 summary across registers, R7 mask gating
    pulse(0, 7);
    pulse(2, 6);
    wr(4'd4, 8'h80);
    wr(4'd6, 8'h40);
    rd_chk(4'd8, 8'h05, "R8");
    irq_chk(1'b0, "R7");
    wr(4'd4, 8'h00);
    rd_chk(4'd8, 8'h04, "R8");
    wr(4'd6, 8'h00);
    irq_chk(1'b1, "R7");
    rd_chk(4'd8, 8'h00, "R8");
    sel_rd(4'd0, 8'h80, 8'h80, "R2");
    sel_rd(4'd2, 8'h40, 8'h40, "R2");

    // R11 address map
    wr(4'd5, 8'hAA);
    rd_chk(4'd5, 8'hAA, "R11");
    wr(4'd8, 8'hFF);
    rd_chk(4'd8, 8'h00, "R11");
    rd_chk(4'd5, 8'hAA, "R11");
    for (int a = 9; a < 16; a++) rd_chk(4'(a), 8'h00, "R11");
    wr(4'd5, 8'h00);
    irq_chk(1'b1, "R11");

    finish_run();
  end
endmodule